// File: doc/BRIEF.md
# GPIO Port Register Bank

A memory-mapped configuration and data block for one 16-pin general-purpose I/O port. Software reaches it through a simple zero-wait 32-bit read/write bus with byte addresses. For each pin it stores a direction/function mode, a driver type, a speed grade, a pull selection and a 4-bit alternate-function number. It also keeps an output data word, which can be written whole or changed atomically through a write-only set/clear port.

On the pad side the block drives, for each pin, an output value, an output enable, an open-drain flag, pull-up and pull-down enables, a speed grade and a 4-bit alternate-function select. Pad levels are synchronized by two flops before software can read them. In alternate mode the pad follows a per-pin peripheral output instead of the output data word. Open-drain pins are driven only while their value is low.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register reads as zero, no pad output enable or pull enable is active, and every alternate-function select is zero.
- R2: The mode (byte offset 0x00, 2 bits per pin at [2p+1:2p]), speed (0x08, same layout) and pull (0x0C, same layout) words read back as written. The driver-type word (0x04, 1 bit per pin, 0 push-pull, 1 open drain) reads back its low 16 bits, and bits 31:16 read as zero.
- R3: A write to the set/clear port (0x18) drives output data bit p high for each set bit p in 15:0 and low for each set bit p+16. Pins whose bits are both zero keep their value. The port always reads as zero.
- R4: When one set/clear write has both bit p and bit p+16 set, pin p ends high.
- R5: A write to the output data word (0x14) replaces all 16 output bits. Reads return the last output values in bits 15:0 and zero in bits 31:16.
- R6: The input data word (0x10) returns pad levels through a two-flop synchronizer. A pad change made between edges becomes visible after the second rising edge and not after the first. Writes to this offset have no effect.
- R7: Alternate-function numbers are 4 bits per pin. Pins 0-7 sit in the word at 0x20 at nibble p%8, and pins 8-15 sit in the word at 0x24 at the same nibble position. Both words read back, and the select output carries pin p's number at bits [4p+3:4p].
- R8: The pad output enable can be active only when the mode is 01 (output) or 10 (alternate). Modes 00 (input) and 11 (analog) never enable the driver.
- R9: In output mode the pad value is the output data bit. In alternate mode it is the pin's peripheral output.
- R10: With open drain selected, a pin in a driving mode is enabled only while its value is 0. The open-drain flag output mirrors the driver-type bit.
- R11: Pull code 01 asserts pull-up, code 10 asserts pull-down, and codes 00 and 11 assert neither.
- R12: Writes to the lock offset (0x1C), to offsets 0x28 and above, and to any address with bits 1:0 not zero change no register. Reads of those addresses return zero.
- R13: The per-pin speed output carries the speed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read access |
| pad_in_i | input | 16 | Pad input levels (asynchronous) |
| periph_out_i | input | 16 | Per-pin peripheral output used in alternate mode |
| pad_out_o | output | 16 | Value presented to each pad |
| pad_oe_o | output | 16 | Pad driver enable |
| pad_od_o | output | 16 | Open-drain driver type per pin |
| pad_pu_o | output | 16 | Pull-up enable |
| pad_pd_o | output | 16 | Pull-down enable |
| pad_speed_o | output | 32 | Speed grade, 2 bits per pin |
| af_sel_o | output | 64 | Alternate-function number, 4 bits per pin |

## Verification
The bench builds the block with its default parameters: 16 pins, 4-bit function numbers, a two-stage synchronizer and a 6-bit byte address. At these values the top pin of each half of the set/clear word is reachable, and so is the boundary between pin 7 and pin 8 where the function numbers change words. So is the first address past the decoded map. The synchronizer depth of two lets the bench tell a one-edge delay from a two-edge delay on the input word.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_ANA = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    PL_NONE = 2'b00,
    PL_UP   = 2'b01,
    PL_DOWN = 2'b10,
    PL_RSVD = 2'b11
  } pull_e;

  // word indices (byte offset / 4)
  localparam int unsigned W_MODE   = 0;
  localparam int unsigned W_OTYPE  = 1;
  localparam int unsigned W_SPEED  = 2;
  localparam int unsigned W_PULL   = 3;
  localparam int unsigned W_IDATA  = 4;
  localparam int unsigned W_ODATA  = 5;
  localparam int unsigned W_SETCLR = 6;
  localparam int unsigned W_LOCK   = 7;
  localparam int unsigned W_AF0    = 8;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned AF_W     = 4,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BUS_W-1:0]         wdata_i,
  output logic [BUS_W-1:0]         rdata_o,
  input  logic [NUM_PINS-1:0]      idata_i,
  output logic [2*NUM_PINS-1:0]    mode_o,
  output logic [NUM_PINS-1:0]      otype_o,
  output logic [2*NUM_PINS-1:0]    speed_o,
  output logic [2*NUM_PINS-1:0]    pull_o,
  output logic [NUM_PINS-1:0]      odata_o,
  output logic [AF_W*NUM_PINS-1:0] af_o
);
  localparam int unsigned IDX_W   = ADDR_W - 2;
  localparam int unsigned AF_PER  = BUS_W / AF_W;
  localparam int unsigned AF_REGS = (NUM_PINS + AF_PER - 1) / AF_PER;
  localparam int unsigned PAD_W   = BUS_W - NUM_PINS;

  logic [IDX_W-1:0] idx;
  logic             aligned, wr_en, rd_en;
  logic             hit_mode, hit_otype, hit_speed, hit_pull, hit_odata, hit_setclr;
  logic [AF_REGS-1:0] hit_af;

  logic [2*NUM_PINS-1:0] mode_q, speed_q, pull_q;
  logic [NUM_PINS-1:0]   otype_q, odata_q;
  logic [AF_W-1:0]       af_q [NUM_PINS];
  logic [BUS_W-1:0]      af_word [AF_REGS];

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_en   = req_i && we_i && aligned;
  assign rd_en   = req_i && !we_i && aligned;

  assign hit_mode   = wr_en && (idx == IDX_W'(W_MODE));
  assign hit_otype  = wr_en && (idx == IDX_W'(W_OTYPE));
  assign hit_speed  = wr_en && (idx == IDX_W'(W_SPEED));
  assign hit_pull   = wr_en && (idx == IDX_W'(W_PULL));
  assign hit_odata  = wr_en && (idx == IDX_W'(W_ODATA));
  assign hit_setclr = wr_en && (idx == IDX_W'(W_SETCLR));

  for (genvar r = 0; r < AF_REGS; r++) begin : g_af_hit
    assign hit_af[r] = wr_en && (idx == IDX_W'(W_AF0 + r));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odata_q <= '0;
    end else begin
      if (hit_mode)  mode_q  <= wdata_i[2*NUM_PINS-1:0];
      if (hit_otype) otype_q <= wdata_i[NUM_PINS-1:0];
      if (hit_speed) speed_q <= wdata_i[2*NUM_PINS-1:0];
      if (hit_pull)  pull_q  <= wdata_i[2*NUM_PINS-1:0];
      if (hit_odata) begin
        odata_q <= wdata_i[NUM_PINS-1:0];
      end else if (hit_setclr) begin
        // set half applied after clear half: set wins
        odata_q <= (odata_q & ~wdata_i[NUM_PINS +: NUM_PINS]) | wdata_i[NUM_PINS-1:0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_af
    localparam int unsigned REG  = p / AF_PER;
    localparam int unsigned SLOT = p % AF_PER;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          af_q[p] <= '0;
      else if (hit_af[REG]) af_q[p] <= wdata_i[SLOT*AF_W +: AF_W];
    end
    assign af_o[p*AF_W +: AF_W] = af_q[p];
  end

  always_comb begin
    for (int r = 0; r < AF_REGS; r++) af_word[r] = '0;
    for (int p = 0; p < NUM_PINS; p++)
      af_word[p / AF_PER][(p % AF_PER)*AF_W +: AF_W] = af_q[p];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (idx == IDX_W'(W_MODE))       rdata_o = mode_q;
      else if (idx == IDX_W'(W_OTYPE)) rdata_o = {{PAD_W{1'b0}}, otype_q};
      else if (idx == IDX_W'(W_SPEED)) rdata_o = speed_q;
      else if (idx == IDX_W'(W_PULL))  rdata_o = pull_q;
      else if (idx == IDX_W'(W_IDATA)) rdata_o = {{PAD_W{1'b0}}, idata_i};
      else if (idx == IDX_W'(W_ODATA)) rdata_o = {{PAD_W{1'b0}}, odata_q};
      else begin
        for (int r = 0; r < AF_REGS; r++)
          if (idx == IDX_W'(W_AF0 + r)) rdata_o = af_word[r];
      end
    end
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign speed_o = speed_q;
  assign pull_o  = pull_q;
  assign odata_o = odata_q;

  // R3
  setclr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_setclr |=> ((odata_q & $past(wdata_i[NUM_PINS-1:0])) == $past(wdata_i[NUM_PINS-1:0])));

  // R3 R4
  setclr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_setclr |=> ((odata_q & $past(wdata_i[NUM_PINS +: NUM_PINS] & ~wdata_i[NUM_PINS-1:0])) == '0));

  // R12
  ignored_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (!aligned || idx == IDX_W'(W_LOCK) || idx == IDX_W'(W_IDATA)
      || idx >= IDX_W'(W_AF0 + AF_REGS)))
    |=> $stable({mode_q, otype_q, speed_q, pull_q, odata_q}));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*NUM_PINS-1:0] mode_i,
  input  logic [NUM_PINS-1:0]   otype_i,
  input  logic [2*NUM_PINS-1:0] pull_i,
  input  logic [NUM_PINS-1:0]   odata_i,
  input  logic [NUM_PINS-1:0]   periph_i,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [NUM_PINS-1:0]   pad_od_o,
  output logic [NUM_PINS-1:0]   pad_pu_o,
  output logic [NUM_PINS-1:0]   pad_pd_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_mode_e m;
    pull_e     pl;
    logic      drv, val;

    assign m   = pin_mode_e'(mode_i[2*p +: 2]);
    assign pl  = pull_e'(pull_i[2*p +: 2]);
    assign drv = (m == PM_OUT) || (m == PM_ALT);
    assign val = (m == PM_ALT) ? periph_i[p] : odata_i[p];

    assign pad_out_o[p] = val;
    assign pad_oe_o[p]  = drv && !(otype_i[p] && val);
    assign pad_od_o[p]  = otype_i[p];
    assign pad_pu_o[p]  = (pl == PL_UP);
    assign pad_pd_o[p]  = (pl == PL_DOWN);

    // R8
    no_drive_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[2*p +: 2] == 2'b00 || mode_i[2*p +: 2] == 2'b11) |-> !pad_oe_o[p]);

    // R10
    od_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pad_od_o[p] && pad_out_o[p]) |-> !pad_oe_o[p]);

    // R11
    pull_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({pad_pu_o[p], pad_pd_o[p]}));
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned AF_W        = 4,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BUS_W-1:0]         wdata_i,
  output logic [BUS_W-1:0]         rdata_o,
  input  logic [NUM_PINS-1:0]      pad_in_i,
  input  logic [NUM_PINS-1:0]      periph_out_i,
  output logic [NUM_PINS-1:0]      pad_out_o,
  output logic [NUM_PINS-1:0]      pad_oe_o,
  output logic [NUM_PINS-1:0]      pad_od_o,
  output logic [NUM_PINS-1:0]      pad_pu_o,
  output logic [NUM_PINS-1:0]      pad_pd_o,
  output logic [2*NUM_PINS-1:0]    pad_speed_o,
  output logic [AF_W*NUM_PINS-1:0] af_sel_o
);
  logic [NUM_PINS-1:0]   idata, otype, odata;
  logic [2*NUM_PINS-1:0] mode, pull;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (idata)
  );

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .AF_W(AF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .idata_i(idata),
    .mode_o (mode),
    .otype_o(otype),
    .speed_o(pad_speed_o),
    .pull_o (pull),
    .odata_o(odata),
    .af_o   (af_sel_o)
  );

  gpio_pad_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .otype_i  (otype),
    .pull_i   (pull),
    .odata_i  (odata),
    .periph_i (periph_out_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o),
    .pad_od_o (pad_od_o),
    .pad_pu_o (pad_pu_o),
    .pad_pd_o (pad_pd_o)
  );
endmodule

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pad_in = '0, periph = '0;
  logic [15:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd;
  logic [31:0] pad_speed;
  logic [63:0] af_sel;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_port_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .periph_out_i(periph),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_od_o(pad_od),
    .pad_pu_o(pad_pu), .pad_pd_o(pad_pd), .pad_speed_o(pad_speed), .af_sel_o(af_sel)
  );

  task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a <= 'h24; a += 4) begin
      rd(6'(a), v);
      chk("R1 reg", {32'd0, v}, 64'd0);
    end
    chk("R1 oe", {48'd0, pad_oe}, 64'd0);
    chk("R1 pulls", {32'd0, pad_pu, pad_pd}, 64'd0);
    chk("R1 af", af_sel, 64'd0);
  endtask

  task automatic t_cfg_rw();
    logic [31:0] v;
    wr(6'h00, 32'h5A5A_F00F); rd(6'h00, v); chk("R2 mode", {32'd0, v}, 64'h5A5A_F00F);
    wr(6'h04, 32'hFFFF_1234); rd(6'h04, v); chk("R2 otype", {32'd0, v}, 64'h1234);
    chk("R10 od flag", {48'd0, pad_od}, 64'h1234);
    wr(6'h08, 32'hC3C3_3C3C); rd(6'h08, v); chk("R2 speed", {32'd0, v}, 64'hC3C3_3C3C);
    chk("R13 speed out", {32'd0, pad_speed}, 64'hC3C3_3C3C);
    wr(6'h0C, 32'h9999_6666); rd(6'h0C, v); chk("R2 pull", {32'd0, v}, 64'h9999_6666);
    wr(6'h00, 32'h0); wr(6'h04, 32'h0); wr(6'h0C, 32'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(6'h14, 32'h0);
    wr(6'h18, 32'h0000_80F0); rd(6'h14, v); chk("R3 set", {32'd0, v}, 64'h80F0);
    wr(6'h18, 32'h8030_0001); rd(6'h14, v); chk("R3 clear", {32'd0, v}, 64'h00C1);
    rd(6'h18, v); chk("R3 reads zero", {32'd0, v}, 64'd0);
    wr(6'h18, 32'h0003_0002); rd(6'h14, v); chk("R4 set wins", {32'd0, v}, 64'h00C2);
  endtask

  task automatic t_odata();
    logic [31:0] v;
    wr(6'h14, 32'hABCD_5555); rd(6'h14, v); chk("R5 odata", {32'd0, v}, 64'h5555);
  endtask

  task automatic t_idata();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 16'hA5C3;
    rd(6'h10, v); chk("R6 no edge", {32'd0, v}, 64'h0);
    @(negedge clk);
    rd(6'h10, v); chk("R6 one edge", {32'd0, v}, 64'h0);
    @(negedge clk);
    rd(6'h10, v); chk("R6 two edges", {32'd0, v}, 64'hA5C3);
    wr(6'h10, 32'h0000_1111); rd(6'h10, v); chk("R6 write ignored", {32'd0, v}, 64'hA5C3);
  endtask

  task automatic t_af();
    logic [31:0] v;
    wr(6'h20, 32'h7654_3210); wr(6'h24, 32'hFEDC_BA98);
    chk("R7 select", af_sel, 64'hFEDC_BA98_7654_3210);
    rd(6'h20, v); chk("R7 low", {32'd0, v}, 64'h7654_3210);
    rd(6'h24, v); chk("R7 high", {32'd0, v}, 64'hFEDC_BA98);
    wr(6'h24, 32'h0000_0005);
    chk("R7 pin8 only", af_sel, 64'h0000_0005_7654_3210);
  endtask

  task automatic t_pad();
    wr(6'h04, 32'h0); wr(6'h14, 32'h00FF); periph = 16'h1234;
    wr(6'h00, 32'h0);
    chk("R8 input no oe", {48'd0, pad_oe}, 64'h0);
    wr(6'h00, 32'h5555_5555);
    chk("R8 output oe", {48'd0, pad_oe}, 64'hFFFF);
    chk("R9 output value", {48'd0, pad_out}, 64'h00FF);
    wr(6'h00, 32'hAAAA_AAAA);
    chk("R9 alt value", {48'd0, pad_out}, 64'h1234);
    chk("R8 alt oe", {48'd0, pad_oe}, 64'hFFFF);
    wr(6'h00, 32'hFFFF_FFFF);
    chk("R8 analog no oe", {48'd0, pad_oe}, 64'h0);
    wr(6'h00, 32'h5555_5555); wr(6'h04, 32'hFFFF);
    chk("R10 open drain", {48'd0, pad_oe}, 64'hFF00);
    wr(6'h00, 32'hAAAA_AAAA);
    chk("R10 od alt", {48'd0, pad_oe}, 64'hEDCB);
    wr(6'h04, 32'h0); wr(6'h00, 32'h0);
  endtask

  task automatic t_pull();
    wr(6'h0C, 32'h0000_00E4);
    chk("R11 pull up", {48'd0, pad_pu}, 64'h0002);
    chk("R11 pull down", {48'd0, pad_pd}, 64'h0004);
    wr(6'h0C, 32'h0);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    wr(6'h00, 32'h1234_5678);
    wr(6'h1C, 32'hFFFF_FFFF); rd(6'h1C, v); chk("R12 lock", {32'd0, v}, 64'h0);
    wr(6'h28, 32'hFFFF_FFFF); rd(6'h28, v); chk("R12 0x28", {32'd0, v}, 64'h0);
    wr(6'h3C, 32'hFFFF_FFFF); rd(6'h3C, v); chk("R12 0x3C", {32'd0, v}, 64'h0);
    wr(6'h01, 32'hFFFF_FFFF); rd(6'h01, v); chk("R12 misaligned rd", {32'd0, v}, 64'h0);
    rd(6'h00, v); chk("R12 mode kept", {32'd0, v}, 64'h1234_5678);
    chk("R12 af kept", af_sel, 64'h0000_0005_7654_3210);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_rw();
    t_setclr();
    t_odata();
    t_idata();
    t_af();
    t_pad();
    t_pull();
    t_unused();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule